// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This unit turns a 32-bit IEEE-754 single-precision bit pattern into a 16-bit half-precision bit pattern. A 2-bit input picks one of four rounding directions for each operand. The unit works out which range of the result format the operand lands in. Every range has its own rule: not-a-number, infinity, overflow beyond the largest finite half value, a normal half result, a subnormal half result, and values too small for any nonzero half. The sign of the operand always passes through to the sign of the result. No exception flags are produced, and a NaN payload is replaced by one fixed quiet NaN.

The exponent and fraction widths of both formats are parameters. All range thresholds and special codes are derived from them. Elaboration fails on a combination the datapath cannot serve. A parameter chooses between a purely combinational path and a version with one output register. In the registered version, the register loads only when the input valid is high, and the output valid follows the input valid one cycle later.

Top module: `f2h_convert`

## Requirements
- R1: If the operand's exponent field is all ones and its fraction is nonzero, the result is 0x7E00 with the operand's sign placed in bit 15.
- R2: If the operand's exponent field is all ones and its fraction is zero, the result is 0x7C00 with the operand's sign in bit 15.
- R3: A finite operand with magnitude of 65536 or more (biased exponent ≥ 143) saturates according to the mode. Nearest-even (mode 00) gives 0x7C00. Toward-zero (mode 01) gives 0x7BFF. Upward (mode 10) gives 0x7C00 when positive and 0x7BFF when negative. Downward (mode 11) gives 0x7BFF when positive and 0x7C00 when negative. The sign goes in bit 15 in every case.
- R4: For biased exponent e from 113 to 142, the unrounded result has exponent field e−112 and takes fraction bits 22:13 as its fraction. The guard bit is operand bit 12, and the sticky bit is the OR of bits 11:0. A carry out of the fraction during rounding propagates into the exponent, which can reach 0x7C00.
- R5: For e from 102 to 112, the result is subnormal. The unrounded magnitude is the 24-bit significand (hidden bit set) shifted right by 126−e. The guard bit is the significand bit just below the kept bits, and the sticky bit is the OR of all lower bits. Rounding may carry the result up to 0x0400.
- R6: Mode encodings: 00 = nearest-even, 01 = toward zero, 10 = upward, 11 = downward. Rounding adds one to the magnitude as follows. Nearest-even adds one when guard is set and either sticky or the magnitude's LSB is set. Upward adds one for a positive operand when guard or sticky is set. Downward does the same for a negative operand. Toward zero never adds.
- R7: A nonzero operand with e below 102 gives magnitude 0x0001 in upward mode when positive and in downward mode when negative. Otherwise it gives magnitude 0. The sign goes in bit 15.
- R8: Positive and negative zero give 0x0000 and 0x8000 in every mode.
- R9: Result bit 15 always equals operand bit 31.
- R10: With the output register selected, out_valid and out_result are 0 after reset. out_valid equals in_valid delayed by one cycle. out_result loads only in cycles with in_valid high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only with the output register) |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| in_operand | input | 32 | Single-precision bit pattern |
| in_mode | input | 2 | Rounding direction select |
| out_valid | output | 1 | Result is valid |
| out_result | output | 16 | Half-precision bit pattern |

## Verification
Each of the 256 exponent values is swept with both signs and all four modes. The fractions used are chosen to separate the rounding cases. A bare zero or a lone LSB tells sticky-only behaviour apart. Exact halfway patterns at the normal and subnormal positions separate ties-to-even from the directed modes. All-ones fractions force a mantissa carry into the exponent and into overflow. Pseudo-random fractions add mixed guard and sticky combinations. Dedicated vectors cover the largest-finite tie that rounds to infinity, the smallest positive and negative inputs in the directed modes, signed zeros, and the register holding steady while in_valid is low.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'b00,
      RND_TO_ZERO   = 2'b01,
      RND_UP        = 2'b10,
      RND_DOWN      = 2'b11
   } rnd_mode_e;

   typedef enum logic [2:0] {
      CLS_NAN  = 3'd0,
      CLS_INF  = 3'd1,
      CLS_OVF  = 3'd2,
      CLS_NORM = 3'd3,
      CLS_SUB  = 3'd4,
      CLS_TINY = 3'd5
   } val_class_e;

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
   import f2h_pkg::*;
#(
   parameter int SRC_EXP_W  = 8,
   parameter int SRC_FRAC_W = 23,
   parameter int DST_EXP_W  = 5,
   parameter int DST_FRAC_W = 10
) (
   input  logic [SRC_EXP_W+SRC_FRAC_W-1:0] mag,
   output val_class_e                      cls,
   output logic                            nonzero
);
   localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
   localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
   localparam int NORM_MIN_E = SRC_BIAS - DST_BIAS + 1;
   localparam int OVF_E      = SRC_BIAS + DST_BIAS + 1;
   localparam int SUB_MIN_E  = NORM_MIN_E - DST_FRAC_W - 1;

   localparam logic [SRC_EXP_W-1:0] OVF_V  = SRC_EXP_W'(OVF_E);
   localparam logic [SRC_EXP_W-1:0] NORM_V = SRC_EXP_W'(NORM_MIN_E);
   localparam logic [SRC_EXP_W-1:0] SUB_V  = SRC_EXP_W'(SUB_MIN_E);

   logic [SRC_EXP_W-1:0]  exp_f;
   logic [SRC_FRAC_W-1:0] frac_f;

   assign exp_f   = mag[SRC_EXP_W+SRC_FRAC_W-1:SRC_FRAC_W];
   assign frac_f  = mag[SRC_FRAC_W-1:0];
   assign nonzero = |mag;

   always_comb begin
      if (&exp_f)
         cls = (|frac_f) ? CLS_NAN : CLS_INF;
      else if (exp_f >= OVF_V)
         cls = CLS_OVF;
      else if (exp_f >= NORM_V)
         cls = CLS_NORM;
      else if (exp_f >= SUB_V)
         cls = CLS_SUB;
      else
         cls = CLS_TINY;
   end
endmodule

// File: rtl/f2h_align.sv
module f2h_align #(
   parameter int SRC_EXP_W  = 8,
   parameter int SRC_FRAC_W = 23,
   parameter int DST_EXP_W  = 5,
   parameter int DST_FRAC_W = 10
) (
   input  logic [SRC_EXP_W+SRC_FRAC_W-1:0] mag,
   input  logic                            is_norm,
   output logic [DST_EXP_W+DST_FRAC_W-1:0] trunc_val,
   output logic                            guard,
   output logic                            sticky
);
   localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
   localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
   localparam int NORM_MIN_E = SRC_BIAS - DST_BIAS + 1;
   localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;
   localparam int MAG_W      = DST_EXP_W + DST_FRAC_W;
   localparam int SIG_W      = SRC_FRAC_W + 2;
   localparam int IW         = $clog2(SRC_FRAC_W + 2);
   localparam int SUB_K      = DROP_W - 1 + NORM_MIN_E;
   localparam logic [IW-1:0] SUB_K_V = IW'(SUB_K % (1 << IW));
   localparam logic [SRC_EXP_W-1:0] EXP_OFS = SRC_EXP_W'(NORM_MIN_E - 1);

   logic [SRC_EXP_W-1:0]  exp_f;
   logic [SRC_FRAC_W-1:0] frac_f;

   assign exp_f  = mag[SRC_EXP_W+SRC_FRAC_W-1:SRC_FRAC_W];
   assign frac_f = mag[SRC_FRAC_W-1:0];

   // normal path: rebias exponent, keep the top fraction bits
   logic [SRC_EXP_W-1:0] rebias;
   logic [MAG_W-1:0]     val_n;
   logic                 guard_n, sticky_n;

   assign rebias   = exp_f - EXP_OFS;
   assign val_n    = {rebias[DST_EXP_W-1:0], frac_f[SRC_FRAC_W-1 -: DST_FRAC_W]};
   assign guard_n  = frac_f[DROP_W-1];
   assign sticky_n = |frac_f[DROP_W-2:0];

   // subnormal path: shift the full significand right by a variable amount
   logic [SIG_W-1:0] sig_ext;
   logic [IW-1:0]    gpos;
   logic [IW:0]      shamt;
   logic [SIG_W-1:0] shifted;
   logic [SIG_W-1:0] low_mask;
   logic [MAG_W-1:0] val_s;
   logic             guard_s, sticky_s;

   assign sig_ext = {1'b0, 1'b1, frac_f};
   assign gpos    = SUB_K_V - exp_f[IW-1:0];
   assign shamt   = {1'b0, gpos} + (IW+1)'(1);

   always_comb begin
      shifted  = sig_ext >> shamt;
      low_mask = SIG_W'(1) << gpos;
      low_mask = low_mask - SIG_W'(1);
   end

   assign val_s    = shifted[MAG_W-1:0];
   assign guard_s  = sig_ext[gpos];
   assign sticky_s = |(sig_ext & low_mask);

   assign trunc_val = is_norm ? val_n    : val_s;
   assign guard     = is_norm ? guard_n  : guard_s;
   assign sticky    = is_norm ? sticky_n : sticky_s;
endmodule

// File: rtl/f2h_round_inc.sv
module f2h_round_inc
   import f2h_pkg::*;
#(
   parameter int MAG_W = 15
) (
   input  logic [MAG_W-1:0] trunc_val,
   input  logic             guard,
   input  logic             sticky,
   input  logic             sign,
   input  rnd_mode_e        mode,
   output logic [MAG_W-1:0] rounded
);
   logic inc;

   always_comb begin
      unique case (mode)
         RND_NEAR_EVEN: inc = guard & (sticky | trunc_val[0]);
         RND_TO_ZERO:   inc = 1'b0;
         RND_UP:        inc = ~sign & (guard | sticky);
         RND_DOWN:      inc = sign & (guard | sticky);
         default:       inc = 1'b0;
      endcase
   end

   assign rounded = trunc_val + MAG_W'(inc);
endmodule

// File: rtl/f2h_convert.sv
module f2h_convert
   import f2h_pkg::*;
#(
   parameter int SRC_EXP_W  = 8,
   parameter int SRC_FRAC_W = 23,
   parameter int DST_EXP_W  = 5,
   parameter int DST_FRAC_W = 10,
   parameter bit OUT_REG    = 1'b1,
   localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W,
   localparam int DST_W     = 1 + DST_EXP_W + DST_FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SRC_W-1:0] in_operand,
   input  logic [1:0]       in_mode,
   output logic             out_valid,
   output logic [DST_W-1:0] out_result
);
   localparam int MAG_W = DST_W - 1;
   localparam logic [MAG_W-1:0] HALF_INF  = {{DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
   localparam logic [MAG_W-1:0] HALF_QNAN = {{DST_EXP_W{1'b1}}, 1'b1, {(DST_FRAC_W-1){1'b0}}};
   localparam logic [MAG_W-1:0] HALF_MAXF = {{(DST_EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};
   localparam logic [MAG_W-1:0] HALF_MIN  = MAG_W'(1);

   // elaboration-time parameter checks
   generate
      if (SRC_EXP_W <= DST_EXP_W) begin : g_bad_exp
         $error("source exponent must be wider than destination exponent");
      end
      if (SRC_FRAC_W < DST_FRAC_W + 2) begin : g_bad_frac
         $error("source fraction needs at least two bits beyond destination fraction");
      end
      if (DST_FRAC_W < 2) begin : g_bad_dfrac
         $error("destination fraction too narrow");
      end
   endgenerate

   logic                           sign;
   logic [SRC_EXP_W+SRC_FRAC_W-1:0] mag;
   rnd_mode_e                      mode;
   val_class_e                     cls;
   logic                           nonzero;
   logic [MAG_W-1:0]               trunc_val, rounded;
   logic                           guard, sticky;
   logic [MAG_W-1:0]               res_mag;
   logic [DST_W-1:0]               res;

   assign sign = in_operand[SRC_W-1];
   assign mag  = in_operand[SRC_W-2:0];
   assign mode = rnd_mode_e'(in_mode);

   f2h_classify #(
      .SRC_EXP_W (SRC_EXP_W),  .SRC_FRAC_W(SRC_FRAC_W),
      .DST_EXP_W (DST_EXP_W),  .DST_FRAC_W(DST_FRAC_W)
   ) i_classify (
      .mag     (mag),
      .cls     (cls),
      .nonzero (nonzero)
   );

   f2h_align #(
      .SRC_EXP_W (SRC_EXP_W),  .SRC_FRAC_W(SRC_FRAC_W),
      .DST_EXP_W (DST_EXP_W),  .DST_FRAC_W(DST_FRAC_W)
   ) i_align (
      .mag       (mag),
      .is_norm   (cls == CLS_NORM),
      .trunc_val (trunc_val),
      .guard     (guard),
      .sticky    (sticky)
   );

   f2h_round_inc #(.MAG_W(MAG_W)) i_round (
      .trunc_val (trunc_val),
      .guard     (guard),
      .sticky    (sticky),
      .sign      (sign),
      .mode      (mode),
      .rounded   (rounded)
   );

   logic [MAG_W-1:0] ovf_mag;
   logic             tiny_bump;

   always_comb begin
      unique case (mode)
         RND_NEAR_EVEN: ovf_mag = HALF_INF;
         RND_TO_ZERO:   ovf_mag = HALF_MAXF;
         RND_UP:        ovf_mag = sign ? HALF_MAXF : HALF_INF;
         RND_DOWN:      ovf_mag = sign ? HALF_INF : HALF_MAXF;
         default:       ovf_mag = HALF_INF;
      endcase
   end

   assign tiny_bump = nonzero & (((mode == RND_UP) & ~sign) | ((mode == RND_DOWN) & sign));

   always_comb begin
      unique case (cls)
         CLS_NAN:  res_mag = HALF_QNAN;
         CLS_INF:  res_mag = HALF_INF;
         CLS_OVF:  res_mag = ovf_mag;
         CLS_NORM: res_mag = rounded;
         CLS_SUB:  res_mag = rounded;
         default:  res_mag = tiny_bump ? HALF_MIN : '0;
      endcase
   end

   assign res = {sign, res_mag};

   generate
      if (OUT_REG) begin : g_reg
         logic             vld_q;
         logic [DST_W-1:0] res_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               res_q <= '0;
            end else begin
               vld_q <= in_valid;
               if (in_valid) res_q <= res;
            end
         end
         assign out_valid  = vld_q;
         assign out_result = res_q;
      end else begin : g_comb
         assign out_valid  = in_valid;
         assign out_result = res;
      end
   endgenerate
endmodule

// File: rtl/f2h_checker.sv
module f2h_checker #(
   parameter int SRC_EXP_W  = 8,
   parameter int SRC_FRAC_W = 23,
   parameter int DST_EXP_W  = 5,
   parameter int DST_FRAC_W = 10,
   parameter bit OUT_REG    = 1'b1,
   localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W,
   localparam int DST_W     = 1 + DST_EXP_W + DST_FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [SRC_W-1:0] in_operand,
   input logic [1:0]       in_mode,
   input logic             out_valid,
   input logic [DST_W-1:0] out_result
);
   localparam int MAG_W      = DST_W - 1;
   localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
   localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
   localparam int NORM_MIN_E = SRC_BIAS - DST_BIAS + 1;
   localparam int OVF_E      = SRC_BIAS + DST_BIAS + 1;
   localparam int SUB_MIN_E  = NORM_MIN_E - DST_FRAC_W - 1;
   localparam logic [MAG_W-1:0] C_INF  = {{DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
   localparam logic [MAG_W-1:0] C_QNAN = {{DST_EXP_W{1'b1}}, 1'b1, {(DST_FRAC_W-1){1'b0}}};
   localparam logic [MAG_W-1:0] C_MAXF = {{(DST_EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};

   logic [SRC_W-1:0] c_op;
   logic [1:0]       c_md;

   generate
      if (OUT_REG) begin : g_pipe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_op <= '0;
               c_md <= '0;
            end else begin
               c_op <= in_operand;
               c_md <= in_mode;
            end
         end

         AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                        // R10
         AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);                                      // R10
         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_result));                             // R10
      end else begin : g_flat
         assign c_op = in_operand;
         assign c_md = in_mode;
      end
   endgenerate

   logic                  c_sgn;
   logic [SRC_EXP_W-1:0]  c_exp;
   logic [SRC_FRAC_W-1:0] c_frac;
   logic [MAG_W-1:0]      o_mag;
   logic [DST_EXP_W-1:0]  o_exp;
   logic [MAG_W-1:0]      ovf_want;

   assign c_sgn  = c_op[SRC_W-1];
   assign c_exp  = c_op[SRC_W-2:SRC_FRAC_W];
   assign c_frac = c_op[SRC_FRAC_W-1:0];
   assign o_mag  = out_result[MAG_W-1:0];
   assign o_exp  = out_result[MAG_W-1:DST_FRAC_W];

   always_comb begin
      case (c_md)
         2'b00:   ovf_want = C_INF;
         2'b01:   ovf_want = C_MAXF;
         2'b10:   ovf_want = c_sgn ? C_MAXF : C_INF;
         default: ovf_want = c_sgn ? C_INF : C_MAXF;
      endcase
   end

   AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&c_exp) && (|c_frac)) |-> (o_mag == C_QNAN));          // R1
   AST_INF_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&c_exp) && !(|c_frac)) |-> (o_mag == C_INF));          // R2
   AST_NO_OVERFLOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(&c_exp) && (int'(c_exp) >= OVF_E)) |-> (o_mag == ovf_want)); // R3
   AST_NORM_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'(c_exp) >= NORM_MIN_E && int'(c_exp) < OVF_E)
      |-> (int'(o_exp) == int'(c_exp) - NORM_MIN_E + 1 ||
           int'(o_exp) == int'(c_exp) - NORM_MIN_E + 2));                   // R4
   AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'(c_exp) >= SUB_MIN_E && int'(c_exp) < NORM_MIN_E)
      |-> (int'(o_exp) <= 1));                                              // R5
   AST_TINY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'(c_exp) < SUB_MIN_E) |-> (o_mag <= MAG_W'(1)));     // R7
   AST_ZERO_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && c_op[SRC_W-2:0] == '0) |-> (o_mag == '0));              // R8
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result[DST_W-1] == c_sgn));                        // R9
endmodule

bind f2h_convert f2h_checker #(
   .SRC_EXP_W  (SRC_EXP_W),
   .SRC_FRAC_W (SRC_FRAC_W),
   .DST_EXP_W  (DST_EXP_W),
   .DST_FRAC_W (DST_FRAC_W),
   .OUT_REG    (OUT_REG)
) i_f2h_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_operand (in_operand),
   .in_mode    (in_mode),
   .out_valid  (out_valid),
   .out_result (out_result)
);

// File: tb/test_f2h_convert.sv
`timescale 1ns/1ps
module test_f2h_convert;
   localparam real HALF_PER = 10.0;
   localparam int  WD_CYC   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_operand = '0;
   logic [1:0]  in_mode = '0;
   logic        out_valid;
   logic [15:0] out_result;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #(HALF_PER) clk = ~clk;

   f2h_convert i_f2h_convert (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_operand (in_operand),
      .in_mode    (in_mode),
      .out_valid  (out_valid),
      .out_result (out_result)
   );

   // arithmetic reference: significand times power of two, quantised to the half ulp
   function automatic logic [15:0] ref_cvt(input logic [31:0] op, input logic [1:0] md);
      logic        s;
      int          e;
      logic [63:0] sig, q, rem, half;
      int          sh;
      bit          up;
      logic [15:0] m;
      s = op[31];
      e = int'(op[30:23]);
      if (e == 255) m = (op[22:0] != 0) ? 16'h7E00 : 16'h7C00;
      else if (e >= 143) begin
         case (md)
            2'd0: m = 16'h7C00;
            2'd1: m = 16'h7BFF;
            2'd2: m = s ? 16'h7BFF : 16'h7C00;
            default: m = s ? 16'h7C00 : 16'h7BFF;
         endcase
      end else if (op[30:0] == 0) m = 16'h0000;
      else if (e < 102) m = ((md == 2'd2 && !s) || (md == 2'd3 && s)) ? 16'h0001 : 16'h0000;
      else begin
         sig  = 64'h80_0000 | 64'(op[22:0]);
         sh   = (e >= 113) ? 13 : 13 + 113 - e;
         q    = sig >> sh;
         rem  = sig & ((64'd1 << sh) - 64'd1);
         half = 64'd1 << (sh - 1);
         case (md)
            2'd0: up = (rem > half) || (rem == half && q[0]);
            2'd1: up = 1'b0;
            2'd2: up = !s && rem != 0;
            default: up = s && rem != 0;
         endcase
         q = q + 64'(up);
         if (e >= 113) q = q + (64'(e - 113) << 10);
         m = q[15:0];
      end
      return {s, 15'd0} | m;
   endfunction

   function automatic string req_of(input logic [31:0] op);
      int e;
      e = int'(op[30:23]);
      if (e == 255) return (op[22:0] != 0) ? "R1" : "R2";
      if (e >= 143) return "R3";
      if (op[30:0] == 0) return "R8";
      if (e < 102) return "R7";
      if (e >= 113) return "R4,R6,R9";
      return "R5,R6,R9";
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
      end
   endtask

   task automatic apply(input logic [31:0] op, input logic [1:0] md, input string req);
      logic [15:0] want;
      want = ref_cvt(op, md);
      @(negedge clk);
      in_valid   = 1'b1;
      in_operand = op;
      in_mode    = md;
      @(posedge clk);
      #1;
      check(out_valid == 1'b1, "R10", 32'(out_valid), 32'd1);
      check(out_result == want, req, 32'(out_result), 32'(want));
   endtask

   initial begin
      logic [31:0] lfsr;
      logic [22:0] fr;
      logic [15:0] held;
      lfsr = 32'hACE1_2468;

      #(HALF_PER * 3);
      // R10 reset state
      check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
      check(out_result == 16'h0, "R10", 32'(out_result), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corner cases
      apply(32'h3F80_0000, 2'd0, "R4");           // 1.0 -> 0x3C00
      apply(32'h477F_F000, 2'd0, "R4,R6");        // tie above max finite -> inf
      apply(32'h477F_F000, 2'd1, "R6");           // truncated -> 0x7BFF
      apply(32'h3300_0001, 2'd0, "R5,R6");        // just above half of min subnormal
      apply(32'h0000_0001, 2'd2, "R7");           // tiny positive up -> 0x0001
      apply(32'h8000_0001, 2'd2, "R7");           // tiny negative up -> 0x8000
      apply(32'h8000_0001, 2'd3, "R7");           // tiny negative down -> 0x8001
      apply(32'h8000_0000, 2'd3, "R8");           // negative zero
      apply(32'h0000_0000, 2'd2, "R8");           // positive zero
      apply(32'hFF80_0001, 2'd1, "R1,R9");        // negative NaN
      apply(32'hC780_0000, 2'd2, "R3");           // -65536 upward -> 0xFBFF
      apply(32'h387F_E000, 2'd0, "R5,R6");        // subnormal carrying into min normal

      // R10: output holds while in_valid is low
      held = out_result;
      @(negedge clk);
      in_valid   = 1'b0;
      in_operand = 32'h4000_0000;
      @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
      check(out_result == held, "R10", 32'(out_result), 32'(held));
      @(negedge clk);
      in_operand = 32'hC120_0000;
      @(posedge clk);
      #1;
      check(out_result == held, "R10", 32'(out_result), 32'(held));

      // sweep: every exponent, both signs, all modes, chosen and random fractions
      for (int e = 0; e < 256; e++) begin
         for (int k = 0; k < 14; k++) begin
            case (k)
               0:  fr = 23'h000000;
               1:  fr = 23'h000001;
               2:  fr = 23'h7FFFFF;
               3:  fr = 23'h001000;
               4:  fr = 23'h001001;
               5:  fr = 23'h000FFF;
               6:  fr = 23'h003000;
               7:  fr = 23'h400000;
               8:  fr = 23'h2AAAAA;
               9:  fr = 23'h555555;
               default: begin
                  lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                  fr   = lfsr[22:0] ^ lfsr[31:9];
               end
            endcase
            for (int sg = 0; sg < 2; sg++) begin
               for (int md = 0; md < 4; md++) begin
                  logic [31:0] op;
                  op = {sg[0], e[7:0], fr};
                  apply(op, md[1:0], req_of(op));
               end
            end
         end
      end

      @(negedge clk);
      in_valid = 1'b0;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(HALF_PER * 2.0 * WD_CYC);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule